// File: doc/BRIEF.md
# Supply-Fault Write Guard Sequencer

This block sits between a host and a byte-wide static memory array and keeps the array safe while the supply is unstable. Two analog comparators report whether the supply is below the deselect level and whether it is below the lower battery-switch level. The block filters both flags, then steps through a small set of modes. In normal running the host strobes pass straight through. When the supply sags, an access that is already under way may finish inside a bounded window, after which the array is deselected. If the supply sags further, the battery feed is selected. On the way back up, protection is held for a long recovery interval before the host regains the array.

All intervals are set in microseconds and converted to clock cycles through a clock-frequency parameter. The host strobes are active low. The current mode is exported as a two-bit code so that surrounding logic can see why the array is unavailable.

Top module: `pwr_guard`

## Requirements
- R1: While reset is held, and directly after it, the mode code is 2'b10 (protected), the three array strobes are high, the bus drive is low and the battery select is low. The block then runs a full recovery interval before normal running.
- R2: Each comparator flag passes through two synchronizing flops and a debounce filter that accepts a new level only after DEB_CYC consecutive cycles. Shorter pulses have no effect on the mode. An accepted change reaches the mode code DEB_CYC+3 clock edges after the input changes.
- R3: In normal running (mode 2'b00) the array strobes equal the host strobes. Bus drive is high exactly when chip enable is low, output enable is low and write enable is high.
- R4: When the deselect flag is accepted while no access is in progress (access-in-progress input low), the next state is protected (2'b10). While in the protected or battery mode, and during recovery, all three array strobes stay high and bus drive stays low, whatever the host inputs are.
- R5: When the deselect flag is accepted while an access is in progress, the mode becomes 2'b01 (pending) and the host strobes still pass through. The mode becomes protected on the clock edge after the access-in-progress input falls.
- R6: The pending mode lasts at most TWP_US*CLK_MHZ cycles. If the access is still running after that, protection is forced.
- R7: If the switchover flag is accepted while the block is pending, protection is forced within FAST_US*CLK_MHZ cycles of that event, even when the protect window is longer.
- R8: An accepted switchover flag moves the protected mode to the battery mode (2'b11) and asserts the battery select. When that flag clears, the block returns to protected with the battery select low. It never goes straight from battery to running.
- R9: After the deselect flag clears in the protected mode, running resumes exactly TER_US*CLK_MHZ cycles after recovery starts. If the deselect flag is accepted again during recovery, the block is protected on the next edge, and the next recovery counts again from zero.
- R10: If the deselect flag clears while the block is pending, it returns to running (2'b00) without a recovery interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| below_pfd_i | input | 1 | Comparator: supply below deselect level (asynchronous) |
| below_so_i | input | 1 | Comparator: supply below battery-switch level (asynchronous) |
| host_ce_n_i | input | 1 | Host chip enable, active low |
| host_oe_n_i | input | 1 | Host output enable, active low |
| host_we_n_i | input | 1 | Host write enable, active low |
| in_cycle_i | input | 1 | High while a host access is in progress |
| mem_ce_n_o | output | 1 | Gated chip enable to the array |
| mem_oe_n_o | output | 1 | Gated output enable to the array |
| mem_we_n_o | output | 1 | Gated write enable to the array |
| bus_drive_o | output | 1 | Data bus output enable (high drives the bus) |
| batt_sel_o | output | 1 | Battery feed select |
| mode_o | output | 2 | Mode code: 00 run/standby, 01 pending, 10 protected, 11 battery |

## Verification
The embedded properties check, on every cycle, that the array stays quiet whenever the block guards it, and that the pending window and the switchover window never exceed their cycle budgets. They also check that the battery mode is left as soon as the switchover flag clears, that a supply drop during recovery restores protection on the next edge, and that the filtered flags only move toward the synchronized level. Only the bench scenarios can show the exact latencies: the debounce delay, the recovery length, and the fact that the recovery count restarts from zero. The same holds for the rejection of short glitches and for the full strobe pass-through table in normal and pending modes.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_PEND  = 3'd1,
        ST_PROT  = 3'd2,
        ST_BATT  = 3'd3,
        ST_RECOV = 3'd4
    } guard_state_e;

    localparam logic [1:0] MODE_RUN  = 2'b00;
    localparam logic [1:0] MODE_PEND = 2'b01;
    localparam logic [1:0] MODE_PROT = 2'b10;
    localparam logic [1:0] MODE_BATT = 2'b11;

    function automatic logic [1:0] mode_code(input guard_state_e st);
        case (st)
            ST_RUN:  mode_code = MODE_RUN;
            ST_PEND: mode_code = MODE_PEND;
            ST_BATT: mode_code = MODE_BATT;
            default: mode_code = MODE_PROT;
        endcase
    endfunction

    function automatic logic is_guarded(input guard_state_e st);
        is_guarded = (st == ST_PROT) || (st == ST_BATT) || (st == ST_RECOV);
    endfunction

endpackage

// File: rtl/pwr_flag_filter.sv
module pwr_flag_filter #(
    parameter int unsigned DEB_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic flt_o
);
    localparam int unsigned CW = $clog2(DEB_CYC + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          stable;
        logic [CW-1:0] cnt;
    } filt_t;

    filt_t flt_d, flt_q;

    always_comb begin
        flt_d    = flt_q;
        flt_d.s1 = raw_i;
        flt_d.s2 = flt_q.s1;
        if (flt_q.s2 == flt_q.stable) begin
            flt_d.cnt = '0;
        end else if (flt_q.cnt == CW'(DEB_CYC - 1)) begin
            flt_d.stable = flt_q.s2;
            flt_d.cnt    = '0;
        end else begin
            flt_d.cnt = flt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q <= '0;
        end else begin
            flt_q <= flt_d;
        end
    end

    assign flt_o = flt_q.stable;

    // R2: the filtered level only ever moves toward the synchronized level
    p_flt_follows_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_q.stable != $past(flt_q.stable)) |-> (flt_q.stable == $past(flt_q.s2)));

endmodule

// File: rtl/pwr_guard_seq.sv
module pwr_guard_seq
    import pwr_guard_pkg::*;
#(
    parameter int unsigned TWP_CYC  = 40,
    parameter int unsigned FAST_CYC = 20,
    parameter int unsigned TER_CYC  = 100
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pfd_i,
    input  logic         so_i,
    input  logic         in_cycle_i,
    output guard_state_e state_o
);
    localparam int unsigned TW = $clog2(TWP_CYC + 1);
    localparam int unsigned FW = $clog2(FAST_CYC + 1);
    localparam int unsigned RW = $clog2(TER_CYC + 1);

    typedef struct packed {
        guard_state_e  state;
        logic [TW-1:0] twp;
        logic [FW-1:0] fast;
        logic [RW-1:0] ter;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.state)
            ST_RUN: begin
                if (pfd_i) begin
                    seq_d.twp   = '0;
                    seq_d.fast  = '0;
                    seq_d.state = in_cycle_i ? ST_PEND : ST_PROT;
                end
            end
            ST_PEND: begin
                if (!pfd_i) begin
                    seq_d.state = ST_RUN;
                end else if (!in_cycle_i) begin
                    seq_d.state = ST_PROT;
                end else if (seq_q.twp == TW'(TWP_CYC - 1)) begin
                    seq_d.state = ST_PROT;
                end else if (so_i && (seq_q.fast == FW'(FAST_CYC - 1))) begin
                    seq_d.state = ST_PROT;
                end else begin
                    seq_d.twp = seq_q.twp + 1'b1;
                    if (so_i) begin
                        seq_d.fast = seq_q.fast + 1'b1;
                    end
                end
            end
            ST_PROT: begin
                if (so_i) begin
                    seq_d.state = ST_BATT;
                end else if (!pfd_i) begin
                    seq_d.state = ST_RECOV;
                    seq_d.ter   = '0;
                end
            end
            ST_BATT: begin
                if (!so_i) begin
                    seq_d.state = ST_PROT;
                end
            end
            ST_RECOV: begin
                if (pfd_i) begin
                    seq_d.state = ST_PROT;
                end else if (seq_q.ter == RW'(TER_CYC - 1)) begin
                    seq_d.state = ST_RUN;
                end else begin
                    seq_d.ter = seq_q.ter + 1'b1;
                end
            end
            default: seq_d.state = ST_PROT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= ST_PROT;
            seq_q.twp   <= '0;
            seq_q.fast  <= '0;
            seq_q.ter   <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state_o = seq_q.state;

    // Independent age counters used only by the checks below
    logic [TW-1:0] pend_age_q;
    logic [FW-1:0] fast_age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_age_q <= '0;
            fast_age_q <= '0;
        end else if (seq_q.state == ST_PEND) begin
            pend_age_q <= pend_age_q + 1'b1;
            if (so_i) begin
                fast_age_q <= fast_age_q + 1'b1;
            end
        end else begin
            pend_age_q <= '0;
            fast_age_q <= '0;
        end
    end

    // R6: pending never outlives the protect window
    p_pend_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_PEND) |-> (pend_age_q < TW'(TWP_CYC)));

    // R7: pending never outlives the switchover window
    p_fast_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_PEND) |-> (fast_age_q < FW'(FAST_CYC)));

    // R8: battery mode is left once the switchover flag clears, never to running
    p_batt_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_q.state == ST_BATT) && !so_i) |=> (seq_q.state == ST_PROT));

    // R9: supply drop during recovery restores protection at once
    p_recov_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_q.state == ST_RECOV) && pfd_i) |=> (seq_q.state == ST_PROT));

    // R10: recovered supply while pending returns straight to running
    p_pend_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_q.state == ST_PEND) && !pfd_i) |=> (seq_q.state == ST_RUN));

endmodule

// File: rtl/pwr_strobe_gate.sv
module pwr_strobe_gate
    import pwr_guard_pkg::*;
(
    input  guard_state_e state_i,
    input  logic         host_ce_n_i,
    input  logic         host_oe_n_i,
    input  logic         host_we_n_i,
    output logic         mem_ce_n_o,
    output logic         mem_oe_n_o,
    output logic         mem_we_n_o,
    output logic         bus_drive_o,
    output logic         batt_sel_o,
    output logic [1:0]   mode_o
);
    always_comb begin
        if (is_guarded(state_i)) begin
            mem_ce_n_o  = 1'b1;
            mem_oe_n_o  = 1'b1;
            mem_we_n_o  = 1'b1;
            bus_drive_o = 1'b0;
        end else begin
            mem_ce_n_o  = host_ce_n_i;
            mem_oe_n_o  = host_oe_n_i;
            mem_we_n_o  = host_we_n_i;
            bus_drive_o = !host_ce_n_i && !host_oe_n_i && host_we_n_i;
        end
        batt_sel_o = (state_i == ST_BATT);
        mode_o     = mode_code(state_i);
    end

endmodule

// File: rtl/pwr_guard.sv
module pwr_guard
    import pwr_guard_pkg::*;
#(
    parameter int unsigned CLK_MHZ = 125,
    parameter int unsigned DEB_CYC = 4,
    parameter int unsigned TWP_US  = 150,
    parameter int unsigned FAST_US = 200,
    parameter int unsigned TER_US  = 40000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       below_pfd_i,
    input  logic       below_so_i,
    input  logic       host_ce_n_i,
    input  logic       host_oe_n_i,
    input  logic       host_we_n_i,
    input  logic       in_cycle_i,
    output logic       mem_ce_n_o,
    output logic       mem_oe_n_o,
    output logic       mem_we_n_o,
    output logic       bus_drive_o,
    output logic       batt_sel_o,
    output logic [1:0] mode_o
);
    localparam int unsigned TWP_CYC  = TWP_US * CLK_MHZ;
    localparam int unsigned FAST_CYC = FAST_US * CLK_MHZ;
    localparam int unsigned TER_CYC  = TER_US * CLK_MHZ;
    localparam int unsigned NFLAG    = 2;

    logic [NFLAG-1:0] raw_flags;
    logic [NFLAG-1:0] flt_flags;
    guard_state_e     state;

    assign raw_flags = {below_so_i, below_pfd_i};

    for (genvar g = 0; g < NFLAG; g++) begin : g_filt
        pwr_flag_filter #(
            .DEB_CYC(DEB_CYC)
        ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw_i(raw_flags[g]),
            .flt_o(flt_flags[g])
        );
    end

    pwr_guard_seq #(
        .TWP_CYC (TWP_CYC),
        .FAST_CYC(FAST_CYC),
        .TER_CYC (TER_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pfd_i     (flt_flags[0]),
        .so_i      (flt_flags[1]),
        .in_cycle_i(in_cycle_i),
        .state_o   (state)
    );

    pwr_strobe_gate u_gate (
        .state_i    (state),
        .host_ce_n_i(host_ce_n_i),
        .host_oe_n_i(host_oe_n_i),
        .host_we_n_i(host_we_n_i),
        .mem_ce_n_o (mem_ce_n_o),
        .mem_oe_n_o (mem_oe_n_o),
        .mem_we_n_o (mem_we_n_o),
        .bus_drive_o(bus_drive_o),
        .batt_sel_o (batt_sel_o),
        .mode_o     (mode_o)
    );

    // R4: a guarded mode keeps the array quiet at the ports
    p_guard_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o[1]) |-> (mem_ce_n_o && mem_oe_n_o && mem_we_n_o && !bus_drive_o));

    // R8: the battery feed is only selected in the battery mode code
    p_batt_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        batt_sel_o |-> (mode_o == MODE_BATT));

endmodule

// File: tb/pwr_guard_bench.sv
module pwr_guard_bench;

    localparam int unsigned DEB  = 3;
    localparam int unsigned TWP  = 40;
    localparam int unsigned FAST = 12;
    localparam int unsigned TER  = 100;
    localparam int unsigned LAT  = DEB + 3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       below_pfd, below_so;
    logic       ce_n, oe_n, we_n, in_cycle;
    logic       mem_ce_n, mem_oe_n, mem_we_n, bus_drive, batt_sel;
    logic [1:0] mode;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    pwr_guard #(
        .CLK_MHZ(1),
        .DEB_CYC(DEB),
        .TWP_US (TWP),
        .FAST_US(FAST),
        .TER_US (TER)
    ) u_pwr_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .below_pfd_i(below_pfd),
        .below_so_i (below_so),
        .host_ce_n_i(ce_n),
        .host_oe_n_i(oe_n),
        .host_we_n_i(we_n),
        .in_cycle_i (in_cycle),
        .mem_ce_n_o (mem_ce_n),
        .mem_oe_n_o (mem_oe_n),
        .mem_we_n_o (mem_we_n),
        .bus_drive_o(bus_drive),
        .batt_sel_o (batt_sel),
        .mode_o     (mode)
    );

    // {ce_n, oe_n, we_n} -> expected {mem_ce_n, mem_oe_n, mem_we_n, bus_drive} when running
    localparam logic [6:0] GATE_VEC [8] = '{
        7'b000_0000, 7'b001_0011, 7'b010_0100, 7'b011_0110,
        7'b100_1000, 7'b101_1010, 7'b110_1100, 7'b111_1110
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic walk_gate(input string req, input bit guarded);
        for (int i = 0; i < 8; i++) begin
            {ce_n, oe_n, we_n} = GATE_VEC[i][6:4];
            #1;
            chk(req, {28'd0, mem_ce_n, mem_oe_n, mem_we_n, bus_drive},
                guarded ? 32'he : {28'd0, GATE_VEC[i][3:0]});
        end
        {ce_n, oe_n, we_n} = 3'b111;
    endtask

    initial begin
        rst_n = 1'b0; below_pfd = 1'b0; below_so = 1'b0;
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; in_cycle = 1'b0;
        adv(3);
        ce_n = 1'b0; we_n = 1'b0; #1;
        chk("R1 mode in reset", mode, 2'b10);
        chk("R1 strobes in reset", {mem_ce_n, mem_oe_n, mem_we_n, bus_drive, batt_sel}, 5'b11100);
        ce_n = 1'b1; we_n = 1'b1;
        rst_n = 1'b1;
        adv(TER);
        chk("R1 still recovering", mode, 2'b10);
        adv(1);
        chk("R1 running after recovery", mode, 2'b00);

        walk_gate("R3 pass-through table", 1'b0);

        // R2: short glitch rejected
        below_pfd = 1'b1; adv(2); below_pfd = 1'b0;
        adv(10);
        chk("R2 glitch ignored", mode, 2'b00);

        // R2/R4: latency and protection with idle host
        below_pfd = 1'b1;
        adv(LAT - 1);
        chk("R2 before latency", mode, 2'b00);
        adv(1);
        chk("R4 protected", mode, 2'b10);
        walk_gate("R4 inputs ignored", 1'b1);

        // R8: battery entry and exit
        below_so = 1'b1; adv(LAT);
        chk("R8 battery mode", {30'd0, mode}, 32'd3);
        chk("R8 battery select", batt_sel, 1'b1);
        walk_gate("R4 ignored in battery", 1'b1);
        below_so = 1'b0; adv(LAT);
        chk("R8 back to protected", {batt_sel, mode}, 3'b010);

        // R9: recovery length
        below_pfd = 1'b0;
        adv(LAT + TER - 1);
        chk("R9 recovery not done", mode, 2'b10);
        adv(1);
        chk("R9 recovery done", mode, 2'b00);

        // R9: restart from zero after a drop during recovery
        below_pfd = 1'b1; adv(LAT);
        below_pfd = 1'b0; adv(LAT + 50);
        chk("R9 mid recovery", mode, 2'b10);
        below_pfd = 1'b1; adv(LAT);
        chk("R9 drop during recovery", mode, 2'b10);
        below_pfd = 1'b0;
        adv(LAT + TER - 1);
        chk("R9 recount not done", mode, 2'b10);
        adv(1);
        chk("R9 recount done", mode, 2'b00);

        // R5: pending access completes
        in_cycle = 1'b1; below_pfd = 1'b1; adv(LAT);
        chk("R5 pending", mode, 2'b01);
        walk_gate("R5 pass-through while pending", 1'b0);
        adv(5);
        in_cycle = 1'b0; adv(1);
        chk("R5 protected after access", mode, 2'b10);
        below_pfd = 1'b0; adv(LAT + TER);
        chk("R5 back to running", mode, 2'b00);

        // R6: protect window forces protection
        in_cycle = 1'b1; below_pfd = 1'b1;
        adv(LAT + TWP - 1);
        chk("R6 last pending cycle", mode, 2'b01);
        adv(1);
        chk("R6 forced protection", mode, 2'b10);
        in_cycle = 1'b0; below_pfd = 1'b0; adv(LAT + TER);
        chk("R6 back to running", mode, 2'b00);

        // R7: switchover during pending shortens the window
        in_cycle = 1'b1; below_pfd = 1'b1; below_so = 1'b1;
        adv(LAT + FAST - 1);
        chk("R7 still pending", mode, 2'b01);
        adv(1);
        chk("R7 forced protection", mode, 2'b10);
        adv(1);
        chk("R7 then battery", {batt_sel, mode}, 3'b111);
        in_cycle = 1'b0; below_pfd = 1'b0; below_so = 1'b0;
        adv(LAT + 1 + TER);
        chk("R7 back to running", mode, 2'b00);

        // R10: supply recovers while pending
        in_cycle = 1'b1; below_pfd = 1'b1; adv(LAT);
        chk("R10 pending", mode, 2'b01);
        below_pfd = 1'b0; adv(LAT);
        chk("R10 running without recovery", mode, 2'b00);
        in_cycle = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule